// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits in front of a small single-port word memory and serves several processor ports. A round-robin arbiter grants one request at a time. Each granted operation runs through a two-state controller. In the first state the word is read. In the second state the old value is modified, written back and returned. Every read-modify-write therefore finishes before any other access reaches the memory.

The unit supports these operations:
- plain load and store
- exchange
- test-and-set (the supplied value is written only when the old word is 0)
- fetch-and-increment
- load-linked and store-conditional

The unit keeps one reservation per port, made of a valid bit and an address. The reservation decides whether a store-conditional may write. Software builds locks from these operations, with 0 meaning free and 1 meaning taken.

Controller states and transitions:
- ST_IDLE: the arbiter is enabled and the memory read is issued for the granted request.
- T_ACCEPT: goes from ST_IDLE to ST_EXEC when a grant is made.
- ST_EXEC: the write-back is done and the response is driven.
- T_DONE: goes from ST_EXEC back to ST_IDLE unconditionally.

Top module: `amo_unit`

## Requirements
- R1: After reset, no response is valid, no port is granted, and every memory word reads as 0.
- R2: Operation codes are 0 load, 1 store, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional, and 7 acts as a load. A load returns the word. A store writes the supplied data and returns 0.
- R3: Exchange writes the supplied data and returns the previous word. An exchange of 1 on a free lock returns 0, and on a held lock it returns 1.
- R4: Test-and-set returns the previous word. It writes the supplied data only if that word was 0, and otherwise leaves memory unchanged.
- R5: Fetch-and-increment returns the word and writes back the word plus one, with wrap-around.
- R6: Load-linked returns the word and records a reservation for the issuing port. A store-conditional from that port to the same address, with no intervening write, writes the data and returns 1 in bit 0, with all other bits 0.
- R7: A store-conditional fails when its port has no reservation or has one on a different address. A failed store-conditional returns 0 and leaves memory unchanged.
- R8: Any store, exchange, successful test-and-set, fetch-and-increment or successful store-conditional clears every other port's reservation on the same address. A write to a different address leaves the reservation intact.
- R9: A store-conditional clears its own port's reservation whether it succeeds or fails. A new load-linked replaces the port's earlier reservation.
- R10: At most one port is granted per cycle, and only a requesting port. Priority rotates: the search starts at the port after the one granted last.
- R11: A grant in cycle t produces a response in cycle t+1 that is tagged with the granted port number. No grant is made in a response cycle, so responses never fall on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | One request flag per port, held until granted |
| req_op | input | NP*3 | Operation code per port |
| req_addr | input | NP*AW | Word address per port |
| req_wdata | input | NP*DW | Store, exchange or increment operand per port |
| req_ready | output | NP | One-hot grant, accepting that port's request this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | $clog2(NP) | Port the response belongs to |
| rsp_data | output | DW | Returned word or store-conditional success bit |

## Verification
Every cycle, the assertions check the grant properties:
- the grant is one-hot and goes only to a requester
- each grant is followed by exactly one response tagged with the same port
- no grant is issued during a response cycle, which is the atomicity guarantee
- a store-conditional result never has bits set above bit 0

Only the bench scenarios can show the values themselves. These are the old-value returns, the conditional writes of test-and-set, and the reservation being lost to another port's write but kept after a write elsewhere. Two further behaviours also rest on the bench alone. All four ports incrementing one word together must each get a distinct count. The rotation order of the grants must match the expected sequence.

// File: rtl/amo_pkg.sv
package amo_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4,
        OP_LL    = 3'd5,
        OP_SC    = 3'd6,
        OP_RSVD  = 3'd7
    } amo_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } amo_state_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
    parameter int NP = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    // Search starts at ptr_q and wraps around the ports (R10)
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 0; k < NP; k++) begin
            int j;
            j = (int'(ptr_q) + k) % NP;
            if (en && req[j] && (gnt == '0)) begin
                gnt[j]  = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt != '0) begin
            ptr_q <= (int'(gnt_idx) == NP - 1) ? '0 : gnt_idx + IW'(1);
        end
    end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
            rdata <= '0;
        end else begin
            rdata <= words[addr];
            if (we) begin
                words[addr] <= wdata;
            end
        end
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv
    import amo_pkg::*;
#(
    parameter int NP = 4,
    parameter int AW = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [IW-1:0] port,
    input  amo_op_e       op,
    input  logic [AW-1:0] addr,
    input  logic          wrote,
    output logic          hit
);
    logic [NP-1:0] rv_q;
    logic [AW-1:0] ra_q [NP];

    for (genvar i = 0; i < NP; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv_q[i] <= 1'b0;
                ra_q[i] <= '0;
            end else if (upd) begin
                if (int'(port) == i) begin
                    if (op == OP_LL) begin
                        rv_q[i] <= 1'b1;       // R9 replace
                        ra_q[i] <= addr;
                    end else if (op == OP_SC) begin
                        rv_q[i] <= 1'b0;       // R9 own clear
                    end
                end else if (wrote && rv_q[i] && (ra_q[i] == addr)) begin
                    rv_q[i] <= 1'b0;           // R8
                end
            end
        end
    end

    assign hit = rv_q[port] && (ra_q[port] == addr);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int NP = 4,
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    req_valid,
    input  logic [NP*3-1:0]  req_op,
    input  logic [NP*AW-1:0] req_addr,
    input  logic [NP*DW-1:0] req_wdata,
    output logic [NP-1:0]    req_ready,
    output logic             rsp_valid,
    output logic [IW-1:0]    rsp_port,
    output logic [DW-1:0]    rsp_data
);
    amo_state_e    state_q, state_d;
    logic [NP-1:0] gnt;
    logic [IW-1:0] gnt_idx;
    logic [IW-1:0] cur_port;
    amo_op_e       cur_op;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          resv_hit;
    logic [DW-1:0] result;
    logic          accept;

    amo_rr_arb #(.NP(NP)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state_q == ST_IDLE),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign accept   = (state_q == ST_IDLE) && (gnt != '0);
    assign mem_addr = (state_q == ST_IDLE) ? req_addr[gnt_idx*AW +: AW] : cur_addr;

    amo_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    amo_resv #(.NP(NP), .AW(AW)) u_resv (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (state_q == ST_EXEC),
        .port  (cur_port),
        .op    (cur_op),
        .addr  (cur_addr),
        .wrote (mem_we),
        .hit   (resv_hit)
    );

    // Next-state: T_ACCEPT and T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_port  <= '0;
            cur_op    <= OP_LOAD;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_port  <= gnt_idx;
                cur_op    <= amo_op_e'(req_op[gnt_idx*3 +: 3]);
                cur_addr  <= req_addr[gnt_idx*AW +: AW];
                cur_wdata <= req_wdata[gnt_idx*DW +: DW];
            end
        end
    end

    // Modify step in ST_EXEC
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = cur_wdata;
        result    = mem_rdata;
        if (state_q == ST_EXEC) begin
            unique case (cur_op)
                OP_STORE: begin
                    mem_we = 1'b1;
                    result = '0;
                end
                OP_SWAP: mem_we = 1'b1;
                OP_TAS:  mem_we = (mem_rdata == '0);
                OP_FINC: begin
                    mem_we    = 1'b1;
                    mem_wdata = mem_rdata + DW'(1);
                end
                OP_SC: begin
                    mem_we = resv_hit;
                    result = {{(DW-1){1'b0}}, resv_hit};
                end
                OP_LOAD, OP_LL, OP_RSVD: result = mem_rdata;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = gnt;
        rsp_valid = (state_q == ST_EXEC);
        rsp_port  = cur_port;
        rsp_data  = rsp_valid ? result : '0;
    end
endmodule

// File: rtl/amo_checker.sv
module amo_checker
    import amo_pkg::*;
#(
    parameter int NP = 4,
    parameter int DW = 32,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] req_valid,
    input logic [NP-1:0] req_ready,
    input logic          rsp_valid,
    input logic [IW-1:0] rsp_port,
    input logic [DW-1:0] rsp_data,
    input amo_op_e       cur_op
);
    logic [IW-1:0] g_enc;
    always_comb begin
        g_enc = '0;
        for (int i = 0; i < NP; i++) begin
            if (req_ready[i]) g_enc = IW'(i);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R10
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n) (req_ready & ~req_valid) == '0); // R10
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (|req_ready) |=> rsp_valid); // R11
    AST_RSP_TAG: assert property (@(posedge clk) disable iff (!rst_n) (|req_ready) |=> (rsp_port == $past(g_enc))); // R11
    AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (req_ready == '0)); // R11
    AST_RSP_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R11
    AST_SC_BIT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && cur_op == OP_SC) |-> (rsp_data[DW-1:1] == '0)); // R6
endmodule

bind amo_unit amo_checker #(.NP(NP), .DW(DW)) u_amo_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_data  (rsp_data),
    .cur_op    (cur_op)
);

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
    localparam int NP = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]    b_valid;
    logic [2:0]       b_op    [NP];
    logic [AW-1:0]    b_addr  [NP];
    logic [DW-1:0]    b_wdata [NP];
    logic [NP-1:0]    req_valid;
    logic [NP*3-1:0]  req_op;
    logic [NP*AW-1:0] req_addr;
    logic [NP*DW-1:0] req_wdata;
    logic [NP-1:0]    req_ready;
    logic             rsp_valid;
    logic [1:0]       rsp_port;
    logic [DW-1:0]    rsp_data;

    always_comb begin
        req_valid = b_valid;
        for (int i = 0; i < NP; i++) begin
            req_op[i*3 +: 3]     = b_op[i];
            req_addr[i*AW +: AW] = b_addr[i];
            req_wdata[i*DW +: DW] = b_wdata[i];
        end
    end

    amo_unit #(.NP(NP), .AW(AW), .DW(DW)) u_amo_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_data(rsp_data)
    );

    int checks = 0;
    int fails = 0;

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]    port;
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 4'd1,  32'd0,  32'd0},  // R1 fresh memory
        '{2'd0, 3'd1, 4'd1,  32'd5,  32'd0},  // R2 store
        '{2'd1, 3'd0, 4'd1,  32'd0,  32'd5},  // R2 load
        '{2'd1, 3'd2, 4'd2,  32'd1,  32'd0},  // R3 lock acquired
        '{2'd2, 3'd2, 4'd2,  32'd1,  32'd1},  // R3 lock held
        '{2'd2, 3'd3, 4'd3,  32'd7,  32'd0},  // R4 old 0, writes
        '{2'd3, 3'd3, 4'd3,  32'd9,  32'd7},  // R4 old nonzero, no write
        '{2'd0, 3'd7, 4'd3,  32'd0,  32'd7},  // R4 unchanged, R2 code 7 loads
        '{2'd0, 3'd4, 4'd4,  32'd0,  32'd0},  // R5
        '{2'd1, 3'd4, 4'd4,  32'd0,  32'd1},  // R5
        '{2'd1, 3'd0, 4'd4,  32'd0,  32'd2},  // R5
        '{2'd0, 3'd5, 4'd5,  32'd0,  32'd0},  // R6 link
        '{2'd0, 3'd6, 4'd5,  32'd11, 32'd1},  // R6 success
        '{2'd0, 3'd0, 4'd5,  32'd0,  32'd11}, // R6 written
        '{2'd0, 3'd6, 4'd5,  32'd12, 32'd0},  // R9 own reservation gone
        '{2'd1, 3'd6, 4'd6,  32'd3,  32'd0},  // R7 no reservation
        '{2'd1, 3'd0, 4'd6,  32'd0,  32'd0},  // R7 memory unchanged
        '{2'd2, 3'd5, 4'd7,  32'd0,  32'd0},  // R8 link
        '{2'd1, 3'd1, 4'd8,  32'd4,  32'd0},  // R8 write elsewhere
        '{2'd2, 3'd6, 4'd7,  32'd8,  32'd1},  // R8 reservation kept
        '{2'd2, 3'd5, 4'd7,  32'd0,  32'd8},  // R8 relink
        '{2'd3, 3'd1, 4'd7,  32'd9,  32'd0},  // R8 other port writes
        '{2'd2, 3'd6, 4'd7,  32'd10, 32'd0},  // R8 reservation lost
        '{2'd2, 3'd0, 4'd7,  32'd0,  32'd9},  // R8 memory kept
        '{2'd3, 3'd5, 4'd9,  32'd0,  32'd0},  // R9 first link
        '{2'd3, 3'd5, 4'd10, 32'd0,  32'd0},  // R9 replacing link
        '{2'd3, 3'd6, 4'd9,  32'd1,  32'd0},  // R9 old address fails
        '{2'd0, 3'd5, 4'd11, 32'd0,  32'd0},  // R7 link
        '{2'd0, 3'd6, 4'd12, 32'd2,  32'd0}   // R7 different address fails
    };

    task automatic do_op(input int p, input logic [2:0] o, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] r,
                         output int rp, output logic rv);
        @(negedge clk);
        b_valid[p] = 1'b1;
        b_op[p]    = o;
        b_addr[p]  = a;
        b_wdata[p] = d;
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
        end
        @(negedge clk);
        b_valid[p] = 1'b0;
        r  = rsp_data;
        rp = int'(rsp_port);
        rv = rsp_valid;
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        int rp;
        logic rv;
        int exp_order [NP];
        b_valid = '0;
        for (int i = 0; i < NP; i++) begin
            b_op[i] = '0; b_addr[i] = '0; b_wdata[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", DW'(rsp_valid), 0);
        check("R1 req_ready after reset", DW'(req_ready), 0);

        for (int v = 0; v < NV; v++) begin
            do_op(int'(VECS[v].port), VECS[v].op, VECS[v].addr, VECS[v].wdata, r, rp, rv);
            check($sformatf("vector %0d data", v), r, VECS[v].exp);
            check($sformatf("R11 vector %0d port tag", v), DW'(rp), DW'(VECS[v].port));
            check($sformatf("R11 vector %0d rsp_valid", v), DW'(rv), 1);
        end

        // R10 and R11: all ports increment one word; last grant was port 0
        exp_order = '{1, 2, 3, 0};
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            b_valid[i] = 1'b1; b_op[i] = 3'd4; b_addr[i] = 4'd13; b_wdata[i] = '0;
        end
        for (int n = 0; n < NP; n++) begin
            int g;
            #1;
            while (req_ready == '0) @(negedge clk);
            g = 0;
            for (int i = 0; i < NP; i++) if (req_ready[i]) g = i;
            check($sformatf("R10 grant %0d", n), DW'(g), DW'(exp_order[n]));
            @(negedge clk);
            b_valid[g] = 1'b0;
            check("R11 tag under contention", DW'(rsp_port), DW'(g));
            check("R11 no grant in response cycle", DW'(req_ready), 0);
            check("R5 distinct increment value", rsp_data, DW'(n));
        end
        do_op(0, 3'd0, 4'd13, 0, r, rp, rv);
        check("R5 final count", r, 4);

        // R5 wrap-around
        do_op(1, 3'd1, 4'd14, 32'hFFFF_FFFF, r, rp, rv);
        do_op(2, 3'd4, 4'd14, 0, r, rp, rv);
        check("R5 wrap old", r, 32'hFFFF_FFFF);
        do_op(2, 3'd0, 4'd14, 0, r, rp, rv);
        check("R5 wrap new", r, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule